// File: doc/BRIEF.md
# Two-Phase Interrupt Status Controller

This block gathers single-cycle event pulses from a camera front-end into banks of sticky status bits and raises an interrupt for software. Each bank has three registers: a mask that decides which status bits may interrupt, a read-only status register, and a clear-staging register. An event pulse always sets its status bit, whatever the mask holds. The mask only decides whether that bit drives the interrupt.

Clearing happens in two phases. Software first writes the bits it wants removed into a bank's staging register, usually the bits it has just read from that bank's status. Nothing changes in the status yet, and several staging writes OR together. Software then writes bit 0 of a shared command register. On that write, every bank removes its staged bits from its status and empties its staging register. An event that arrives in the same cycle as the commit keeps its bit set, so no event is lost. This lets a handler read and acknowledge all banks and then commit them together.

Software assigns meaning to bit positions. In bank 0, bit 31 is the reset acknowledge, bit 0 is frame start, bit 1 is frame end, and bit 5+n is register-update-done for input line n (n = 0..3). In bank 1, bit 7 is an access violation, bit 8 is a bus halt acknowledge, and bit 9+n is a bus overflow for image master n. Before a reset, software writes a bank 0 mask with only bit 31 set, so that only the reset acknowledge can interrupt.

Top module: `irq_stat_ctrl`

## Requirements
- R1: After reset, every mask, status and staging register reads 0 and irq_o is low.
- R2: An event pulse on bit i of bank b sets status bit i of bank b at the next clock edge, whatever the mask holds, and the bit stays set until a commit removes it.
- R3: A write to a bank's staging register (word address 4*b+1) ORs the written bits into that register, and the accumulated value reads back at the same address. Such a write leaves the status unchanged.
- R4: A write with bit 0 set to the command register (word address 4*NUM_BANKS) removes the staged bits from each bank's status at that edge and zeroes every staging register. A command write with bit 0 clear has no effect.
- R5: If an event pulse for a bit arrives in the same cycle as a commit that removes that bit, the bit stays set.
- R6: irq_o is registered. It is high in the cycle after a cycle in which any bank has a status bit set whose mask bit is also set, and low otherwise.
- R7: A write to a bank's mask register (word address 4*b) replaces the mask. With bank 0 masked to bit 31 only, events on other bits set status but do not raise irq_o, and a reset-acknowledge event on bit 31 does raise it.
- R8: Each bank clears only by its own staged bits, so a commit leaves unstaged bits, including all bits of other banks, set.
- R9: The status register is read at word address 4*b+2. Reads of word address 4*b+3, of the command register, and of any address above the command register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_BANKS*DATA_W | Event pulses; bank b occupies bits [b*DATA_W +: DATA_W] |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an event that lands in exactly the cycle of the commit write and on a bit that is staged. From the ports, this needs a staging write, then a command write driven in the same cycle as the event pulse. The bench reaches it by passing the event vector and the register write to one step task, so both are applied at the same negative edge. The bench also sets up partly staged banks with events pending in the other bank, which tests that a commit is confined to each bank's own staged bits.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
   // register select codes within a bank's four-word window
   localparam logic [1:0] SEL_MASK  = 2'd0;
   localparam logic [1:0] SEL_STAGE = 2'd1;
   localparam logic [1:0] SEL_STAT  = 2'd2;
   localparam logic [1:0] SEL_RSVD  = 2'd3;

   // software-visible bit assignments
   localparam int B0_FRAME_START = 0;
   localparam int B0_FRAME_END   = 1;
   localparam int B0_LINE_UPD0   = 5;
   localparam int B0_RESET_ACK   = 31;
   localparam int B1_VIOLATION   = 7;
   localparam int B1_HALT_ACK    = 8;
   localparam int B1_OVERFLOW0   = 9;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_i,
   input  logic              mask_we,
   input  logic              stage_we,
   input  logic              commit,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_o,
   output logic [DATA_W-1:0] stage_o,
   output logic [DATA_W-1:0] stat_o,
   output logic              hit_o
);
   logic [DATA_W-1:0] mask_q, stage_q, stat_q;
   logic [DATA_W-1:0] drop;

   assign drop = commit ? stage_q : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         stage_q <= '0;
         stat_q  <= '0;
      end else begin
         if (mask_we)
            mask_q <= wdata;
         if (commit)
            stage_q <= '0;
         else if (stage_we)
            stage_q <= stage_q | wdata;
         // new events win over a committed clear
         stat_q <= (stat_q & ~drop) | evt_i;
      end
   end

   assign mask_o  = mask_q;
   assign stage_o = stage_q;
   assign stat_o  = stat_q;
   assign hit_o   = |(stat_q & mask_q);
endmodule

// File: rtl/irq_stat_dec.sv
module irq_stat_dec
   import irq_stat_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_BANKS = 2,
   parameter int ADDR_W    = 4
) (
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        cmd_bit,
   input  logic [NUM_BANKS*DATA_W-1:0] mask_flat,
   input  logic [NUM_BANKS*DATA_W-1:0] stage_flat,
   input  logic [NUM_BANKS*DATA_W-1:0] stat_flat,
   output logic [NUM_BANKS-1:0]        mask_we,
   output logic [NUM_BANKS-1:0]        stage_we,
   output logic                        commit,
   output logic [DATA_W-1:0]           rdata
);
   localparam int BW       = ADDR_W - 2;
   localparam int CMD_ADDR = NUM_BANKS * 4;

   logic [BW-1:0] bidx;
   logic [1:0]    sel;

   assign bidx   = addr[ADDR_W-1:2];
   assign sel    = addr[1:0];
   assign commit = wr_en && (addr == ADDR_W'(CMD_ADDR)) && cmd_bit;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strb
      assign mask_we[b]  = wr_en && (bidx == BW'(b)) && (sel == SEL_MASK);
      assign stage_we[b] = wr_en && (bidx == BW'(b)) && (sel == SEL_STAGE);
   end

   always_comb begin
      rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bidx == BW'(b)) begin
            case (sel)
               SEL_MASK:  rdata = mask_flat[b*DATA_W +: DATA_W];
               SEL_STAGE: rdata = stage_flat[b*DATA_W +: DATA_W];
               SEL_STAT:  rdata = stat_flat[b*DATA_W +: DATA_W];
               default:   rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
   import irq_stat_pkg::*;
#(
   parameter  int DATA_W    = 32,
   parameter  int NUM_BANKS = 2,
   localparam int ADDR_W    = $clog2(NUM_BANKS*4 + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*DATA_W-1:0] evt_i,
   input  logic                        wr_en_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [DATA_W-1:0]           wdata_i,
   output logic [DATA_W-1:0]           rdata_o,
   output logic                        irq_o
);
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("irq_stat_ctrl: NUM_BANKS must be at least 1");
   end
   if (DATA_W <= B0_RESET_ACK) begin : g_bad_width
      $error("irq_stat_ctrl: DATA_W must hold the reset-acknowledge bit");
   end

   logic [NUM_BANKS*DATA_W-1:0] mask_flat, stage_flat, stat_flat;
   logic [NUM_BANKS-1:0]        mask_we, stage_we, hit;
   logic                        commit_w;
   logic                        irq_q;

   irq_stat_dec #(
      .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
   ) u_dec (
      .wr_en(wr_en_i), .addr(addr_i), .cmd_bit(wdata_i[0]),
      .mask_flat(mask_flat), .stage_flat(stage_flat), .stat_flat(stat_flat),
      .mask_we(mask_we), .stage_we(stage_we), .commit(commit_w),
      .rdata(rdata_o)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irq_stat_bank #(.DATA_W(DATA_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .evt_i(evt_i[b*DATA_W +: DATA_W]),
         .mask_we(mask_we[b]), .stage_we(stage_we[b]), .commit(commit_w),
         .wdata(wdata_i),
         .mask_o(mask_flat[b*DATA_W +: DATA_W]),
         .stage_o(stage_flat[b*DATA_W +: DATA_W]),
         .stat_o(stat_flat[b*DATA_W +: DATA_W]),
         .hit_o(hit[b])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |hit;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
   parameter int DATA_W    = 32,
   parameter int NUM_BANKS = 2,
   parameter int ADDR_W    = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_BANKS*DATA_W-1:0] evt_i,
   input logic [ADDR_W-1:0]           addr_i,
   input logic [DATA_W-1:0]           rdata_o,
   input logic                        irq_o,
   input logic                        commit,
   input logic [NUM_BANKS*DATA_W-1:0] stat_flat,
   input logic [NUM_BANKS*DATA_W-1:0] mask_flat,
   input logic [NUM_BANKS*DATA_W-1:0] stage_flat
);
   localparam int CMD_ADDR = NUM_BANKS * 4;

   // R2
   ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((stat_flat & $past(evt_i)) == $past(evt_i)));

   // R3
   no_commit_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ((stat_flat & $past(stat_flat)) == $past(stat_flat)));

   // R4
   commit_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (stage_flat == '0));

   // R5
   commit_evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (|evt_i)) |=> ((stat_flat & $past(evt_i)) == $past(evt_i)));

   // R6
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|(stat_flat & mask_flat)));

   // R9
   rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((addr_i[1:0] == 2'd3) || (int'(addr_i) >= CMD_ADDR)) |-> (rdata_o == '0));
endmodule

bind irq_stat_ctrl irq_stat_chk #(
   .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr_i(addr_i),
   .rdata_o(rdata_o), .irq_o(irq_o), .commit(commit_w),
   .stat_flat(stat_flat), .mask_flat(mask_flat), .stage_flat(stage_flat)
);

// File: tb/tb_irq_stat_ctrl.sv
`timescale 1ns/1ps
module tb_irq_stat_ctrl;
   localparam int AW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] evt = '0;
   logic        we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int vectors = 0;
   int fails = 0;

   // behavioural model state
   logic [31:0] m_mask [2];
   logic [31:0] m_stage[2];
   logic [31:0] m_stat [2];
   logic        m_irq;

   always #10 clk = ~clk;

   irq_stat_ctrl dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   function automatic logic [31:0] m_read(input int a);
      case (a)
         0: return m_mask[0];
         1: return m_stage[0];
         2: return m_stat[0];
         4: return m_mask[1];
         5: return m_stage[1];
         6: return m_stat[1];
         default: return 32'h0;
      endcase
   endfunction

   task automatic m_clock();
      logic [31:0] ns[2], nst[2], nm[2];
      bit cm;
      logic ni;
      cm = we && (addr == 4'd8) && wdata[0];
      ni = |(m_stat[0] & m_mask[0]) || |(m_stat[1] & m_mask[1]);
      for (int b = 0; b < 2; b++) begin
         nm[b]  = (we && addr == 4'(4*b)) ? wdata : m_mask[b];
         nst[b] = cm ? 32'h0 : ((we && addr == 4'(4*b+1)) ? (m_stage[b] | wdata) : m_stage[b]);
         ns[b]  = (cm ? (m_stat[b] & ~m_stage[b]) : m_stat[b]) | evt[b*32 +: 32];
      end
      for (int b = 0; b < 2; b++) begin
         m_mask[b] = nm[b]; m_stage[b] = nst[b]; m_stat[b] = ns[b];
      end
      m_irq = ni;
   endtask

   task automatic step(input string tag, input bit w, input int a,
                       input logic [31:0] d, input logic [63:0] e);
      logic [31:0] exp_r;
      @(negedge clk);
      we = w; addr = AW'(a); wdata = d; evt = e;
      #1;
      exp_r = m_read(a);
      vectors++;
      if (rdata !== exp_r || irq !== m_irq) begin
         fails++;
         $display("FAIL %s addr=%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                  tag, a, rdata, irq, exp_r, m_irq);
      end
      @(posedge clk);
      #1 m_clock();
   endtask

   task automatic rd(input string tag, input int a);
      step(tag, 1'b0, a, 32'h0, 64'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      for (int b = 0; b < 2; b++) begin
         m_mask[b] = '0; m_stage[b] = '0; m_stat[b] = '0;
      end
      m_irq = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state on every register
      for (int a = 0; a < 16; a++) rd("R1", a);

      // R2: frame start/end events set status with mask clear, no irq
      step("R2", 1'b0, 2, 32'h0, 64'h3);
      rd("R2", 2);
      rd("R2", 2);
      step("R2", 1'b0, 6, 32'h0, 64'h0000_0100_0000_0000); // bank1 halt ack
      rd("R2", 6);

      // R3: staging accumulates, status untouched
      step("R3", 1'b1, 1, 32'h1, 64'h0);
      step("R3", 1'b1, 1, 32'h2, 64'h0);
      rd("R3", 1);
      rd("R3", 2);

      // R4: command with bit0 clear does nothing, with bit0 set commits
      step("R4", 1'b1, 8, 32'h2, 64'h0);
      rd("R4", 2);
      rd("R4", 1);
      step("R4", 1'b1, 8, 32'h1, 64'h0);
      rd("R4", 2);
      rd("R4", 1);

      // R7: mask only reset-ack; line-update event does not interrupt
      step("R7", 1'b1, 0, 32'h8000_0000, 64'h0);
      rd("R7", 0);
      step("R7", 1'b0, 2, 32'h0, 64'h20);
      rd("R7", 2);
      rd("R7", 2);
      // R6: reset-ack raises irq one cycle after status
      step("R6", 1'b0, 2, 32'h0, 64'h8000_0000);
      rd("R6", 2);
      rd("R6", 2);

      // R8: bank1 violation + overflow0, stage only violation in bank1
      step("R8", 1'b0, 6, 32'h0, 64'h0000_0280_0000_0000);
      step("R8", 1'b1, 5, 32'h80, 64'h0);
      rd("R8", 5);
      step("R8", 1'b1, 8, 32'h1, 64'h0);
      rd("R8", 6);
      rd("R8", 2);
      rd("R8", 5);

      // R5: stage bits 31 and 5, commit with a new bit-31 event
      step("R5", 1'b1, 1, 32'h8000_0020, 64'h0);
      step("R5", 1'b1, 8, 32'h1, 64'h8000_0000);
      rd("R5", 2);
      rd("R5", 1);

      // R9: reserved and command reads return zero
      rd("R9", 3);
      rd("R9", 7);
      rd("R9", 8);
      rd("R9", 15);

      // R6: bank1 mask drives irq, then all masks cleared drop it
      step("R6", 1'b1, 0, 32'h0, 64'h0);
      rd("R6", 2);
      rd("R6", 2);
      step("R6", 1'b1, 4, 32'hFFFF_FFFF, 64'h0);
      rd("R6", 6);
      rd("R6", 6);
      step("R6", 1'b1, 4, 32'h0, 64'h0);
      rd("R6", 4);
      rd("R6", 4);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule